// File: doc/BRIEF.md
# Power and Sleep Transition Controller

This block sequences a small array of power domains, each of which holds one gated module. Software works through a 32-bit register port. It first writes the state it wants for a module and, when the domain is off, sets a power-on request. Nothing changes at that point. The change starts only when software sets the domain's bit in a command register. The domain's sequencer then runs through an optional power-up phase and a module phase, each a fixed number of clock cycles. At the end of the module phase it applies the new state in one step.

A busy bitmap shows which domains are still moving. Each domain also has a domain status word and a module status word. The module status carries the applied state, the local-reset level and a clock-running flag. Per module, the block drives a clock enable and an active-low reset. The power switches and the module clock tree are not modelled as hardware. They appear only as the fixed phase lengths set by `PUP_CYC` and `MOD_CYC`.

Writes take effect at the clock edge where `wr_en` is high. Reads are combinational from `rd_addr`.

Top module: `pwr_seq_ctrl`

## Requirements
- R1: After reset the busy bitmap is zero, every domain status reads 0 (off), every module status reads 0 (state 0, reset asserted, clock stopped), and every `mod_clk_en` and `mod_rst_n` output is 0.
- R2: The module control word for domain d sits at byte address 0xA00+4d and reads back only these fields: requested state in bits [5:0], the local-reset release bit in bit 8 (1 = release), and the force bit in bit 31. Other bits read 0. The domain control word at 0x300+4d reads back only bit 0, the power-on request.
- R3: Any read of an address outside the mapped words returns zero. This covers a domain index of N_DOM or more, an address that is not a multiple of 4, and any unmapped page. Writes to such addresses change no register.
- R4: Writing 1 to bit d at 0x120 starts a transition of domain d. Bit d of 0x128 reads 1 from the cycle after that write until the transition ends. Reads of 0x120 return 0.
- R5: A transition lasts exactly MOD_CYC cycles when no power-up is needed. It lasts PUP_CYC+MOD_CYC cycles when the domain is off and its power-on request bit is set at the time of the command.
- R6: Domain status bits [4:0] at 0x200+4d read 1 once the power-up phase ends and stay 1. A domain whose request bit is clear at the command stays at 0.
- R7: The state field [5:0] of the module status at 0x800+4d, and the module outputs, change only when a transition completes. Writing module control without a command has no visible effect.
- R8: Module status bit 12 and `mod_clk_en[d]` are 1 exactly when the applied state is 3 (enable). The state codes are 0 = reset-and-disabled, 1 = synchronous reset, 2 = disabled, 3 = enabled.
- R9: `mod_rst_n[d]` and module status bit 8 are 1 only when the applied state is enable and the release bit was 1 at the command. Completing a move to disable always leaves the reset asserted.
- R10: A command bit for a domain that is already busy is ignored. It neither lengthens the transition nor queues a second one.
- R11: Domains commanded in the same write run independently, each with its own duration and result. A transition in one domain leaves the others unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 12 | Write byte address |
| wr_data | input | 32 | Write data |
| rd_addr | input | 12 | Read byte address |
| rd_data | output | 32 | Combinational read data |
| mod_clk_en | output | N_DOM | Per-module clock enable |
| mod_rst_n | output | N_DOM | Per-module active-low local reset |

## Verification
The hardest situation to reach is a command that arrives for a domain while that domain is in the middle of its own transition. It is made worse when another domain is started in the same write and its power-up must overlap. The bench builds the first case by watching the busy bitmap every cycle and issuing a second command for the same domain on the third busy cycle. It then checks that the measured busy length still equals the power-up plus module length, and that nothing restarts afterwards. A follow-up scenario starts one already-powered domain and one unpowered domain with a single write. It counts each domain's busy cycles separately and checks each against its own expected length and final state.

// File: rtl/pwr_seq_pkg.sv
package pwr_seq_pkg;

   // sequencer phase of one domain
   typedef enum logic [1:0] {
      PH_IDLE = 2'd0,
      PH_PWR  = 2'd1,
      PH_MOD  = 2'd2
   } phase_t;

   // module state codes (software visible)
   localparam logic [5:0] MST_RSTDIS  = 6'd0;
   localparam logic [5:0] MST_SYNCRST = 6'd1;
   localparam logic [5:0] MST_DISABLE = 6'd2;
   localparam logic [5:0] MST_ENABLE  = 6'd3;

   // register map
   localparam logic [11:0] OFS_CMD    = 12'h120;
   localparam logic [11:0] OFS_STAT   = 12'h128;
   localparam logic [3:0]  PAGE_DSTAT = 4'h2;
   localparam logic [3:0]  PAGE_DCTL  = 4'h3;
   localparam logic [3:0]  PAGE_MSTAT = 4'h8;
   localparam logic [3:0]  PAGE_MCTL  = 4'hA;

   // field positions
   localparam int BIT_LRST  = 8;
   localparam int BIT_FORCE = 31;
   localparam int BIT_CLKON = 12;
   localparam int BIT_NEXT  = 0;

   localparam logic [4:0] DST_OFF = 5'd0;
   localparam logic [4:0] DST_ON  = 5'd1;

   typedef struct packed {
      logic       force_b;
      logic       lrst_n;
      logic [5:0] state;
   } modctl_t;

endpackage

// File: rtl/pwr_seq_dom.sv
module pwr_seq_dom
   import pwr_seq_pkg::*;
#(
   parameter int PUP_CYC = 6,
   parameter int MOD_CYC = 4
) (
   input  logic       clk,
   input  logic       rst_n,
   input  logic       go,
   input  logic       next_req,
   input  logic [5:0] tgt_state,
   input  logic       tgt_lrst_n,
   output logic       busy,
   output logic       pwr_on,
   output logic [5:0] cur_state,
   output logic       cur_lrst_n
);

   localparam int MAXC  = (PUP_CYC > MOD_CYC) ? PUP_CYC : MOD_CYC;
   localparam int CNT_W = $clog2(MAXC + 1);

   phase_t           phase_q;
   logic [CNT_W-1:0] cnt_q;
   logic [5:0]       tgt_q;
   logic             tgt_lrst_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         phase_q    <= PH_IDLE;
         cnt_q      <= '0;
         tgt_q      <= MST_RSTDIS;
         tgt_lrst_q <= 1'b0;
         pwr_on     <= 1'b0;
         cur_state  <= MST_RSTDIS;
         cur_lrst_n <= 1'b0;
      end else begin
         unique case (phase_q)
            PH_IDLE: begin
               if (go) begin
                  tgt_q      <= tgt_state;
                  tgt_lrst_q <= tgt_lrst_n;
                  if (!pwr_on && next_req) begin
                     phase_q <= PH_PWR;
                     cnt_q   <= CNT_W'(PUP_CYC - 1);
                  end else begin
                     phase_q <= PH_MOD;
                     cnt_q   <= CNT_W'(MOD_CYC - 1);
                  end
               end
            end
            PH_PWR: begin
               if (cnt_q == '0) begin
                  pwr_on  <= 1'b1;
                  phase_q <= PH_MOD;
                  cnt_q   <= CNT_W'(MOD_CYC - 1);
               end else begin
                  cnt_q <= cnt_q - 1'b1;
               end
            end
            PH_MOD: begin
               if (cnt_q == '0) begin
                  cur_state  <= tgt_q;
                  // only an enabled module may leave local reset
                  cur_lrst_n <= (tgt_q == MST_ENABLE) && tgt_lrst_q;
                  phase_q    <= PH_IDLE;
               end else begin
                  cnt_q <= cnt_q - 1'b1;
               end
            end
            default: phase_q <= PH_IDLE;
         endcase
      end
   end

   assign busy = (phase_q != PH_IDLE);

endmodule

// File: rtl/pwr_seq_regs.sv
module pwr_seq_regs
   import pwr_seq_pkg::*;
#(
   parameter int N_DOM = 4
) (
   input  logic                  clk,
   input  logic                  rst_n,
   input  logic                  wr_en,
   input  logic [11:0]           wr_addr,
   input  logic [31:0]           wr_data,
   input  logic [11:0]           rd_addr,
   output logic [31:0]           rd_data,
   input  logic [N_DOM-1:0]      busy,
   input  logic [N_DOM-1:0]      pwr_on,
   input  logic [N_DOM-1:0]      cur_lrst_n,
   input  logic [N_DOM-1:0][5:0] cur_state,
   output logic [N_DOM-1:0]      go,
   output logic [N_DOM-1:0]      next_req,
   output logic [N_DOM-1:0]      tgt_lrst_n,
   output logic [N_DOM-1:0][5:0] tgt_state
);

   localparam int IDX_W = 6;

   modctl_t          mc_q [N_DOM];
   logic [N_DOM-1:0] next_q;
   logic             unused_wr;

   function automatic logic slot_hit(input logic [11:0] a,
                                     input logic [3:0]  page,
                                     input int          d);
      return (a[11:8] == page) && (a[1:0] == 2'b00) &&
             (a[7:2] == IDX_W'(d));
   endfunction

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         next_q <= '0;
         for (int d = 0; d < N_DOM; d++) mc_q[d] <= '0;
      end else if (wr_en) begin
         for (int d = 0; d < N_DOM; d++) begin
            if (slot_hit(wr_addr, PAGE_DCTL, d))
               next_q[d] <= wr_data[BIT_NEXT];
            if (slot_hit(wr_addr, PAGE_MCTL, d))
               mc_q[d] <= '{force_b: wr_data[BIT_FORCE],
                            lrst_n:  wr_data[BIT_LRST],
                            state:   wr_data[5:0]};
         end
      end
   end

   wire cmd_wr = wr_en && (wr_addr == OFS_CMD);

   for (genvar g = 0; g < N_DOM; g++) begin : g_dom
      assign go[g]         = cmd_wr && wr_data[g] && !busy[g];
      assign next_req[g]   = next_q[g];
      assign tgt_lrst_n[g] = mc_q[g].lrst_n;
      assign tgt_state[g]  = mc_q[g].state;
   end

   assign unused_wr = ^wr_data;

   always_comb begin
      rd_data = '0;
      if (rd_addr == OFS_STAT) rd_data[N_DOM-1:0] = busy;
      for (int d = 0; d < N_DOM; d++) begin
         if (slot_hit(rd_addr, PAGE_DSTAT, d))
            rd_data[4:0] = pwr_on[d] ? DST_ON : DST_OFF;
         if (slot_hit(rd_addr, PAGE_DCTL, d))
            rd_data[BIT_NEXT] = next_q[d];
         if (slot_hit(rd_addr, PAGE_MCTL, d)) begin
            rd_data[5:0]      = mc_q[d].state;
            rd_data[BIT_LRST] = mc_q[d].lrst_n;
            rd_data[BIT_FORCE] = mc_q[d].force_b;
         end
         if (slot_hit(rd_addr, PAGE_MSTAT, d)) begin
            rd_data[5:0]       = cur_state[d];
            rd_data[BIT_LRST]  = cur_lrst_n[d];
            rd_data[BIT_CLKON] = (cur_state[d] == MST_ENABLE);
         end
      end
   end

endmodule

// File: rtl/pwr_seq_ctrl.sv
module pwr_seq_ctrl
   import pwr_seq_pkg::*;
#(
   parameter int N_DOM   = 4,
   parameter int PUP_CYC = 6,
   parameter int MOD_CYC = 4
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             wr_en,
   input  logic [11:0]      wr_addr,
   input  logic [31:0]      wr_data,
   input  logic [11:0]      rd_addr,
   output logic [31:0]      rd_data,
   output logic [N_DOM-1:0] mod_clk_en,
   output logic [N_DOM-1:0] mod_rst_n
);

   // elaboration-time parameter checks
   if (N_DOM < 1 || N_DOM > 32) begin : g_bad_ndom
      $error("pwr_seq_ctrl: N_DOM must be 1..32");
   end
   if (PUP_CYC < 1 || MOD_CYC < 1) begin : g_bad_cyc
      $error("pwr_seq_ctrl: phase lengths must be at least 1");
   end

   logic [N_DOM-1:0]      busy_v;
   logic [N_DOM-1:0]      pwr_v;
   logic [N_DOM-1:0]      cur_lrst_v;
   logic [N_DOM-1:0][5:0] cur_state_v;
   logic [N_DOM-1:0]      go_v;
   logic [N_DOM-1:0]      next_v;
   logic [N_DOM-1:0]      tgt_lrst_v;
   logic [N_DOM-1:0][5:0] tgt_state_v;

   pwr_seq_regs #(.N_DOM(N_DOM)) u_regs (
      .clk        (clk),
      .rst_n      (rst_n),
      .wr_en      (wr_en),
      .wr_addr    (wr_addr),
      .wr_data    (wr_data),
      .rd_addr    (rd_addr),
      .rd_data    (rd_data),
      .busy       (busy_v),
      .pwr_on     (pwr_v),
      .cur_lrst_n (cur_lrst_v),
      .cur_state  (cur_state_v),
      .go         (go_v),
      .next_req   (next_v),
      .tgt_lrst_n (tgt_lrst_v),
      .tgt_state  (tgt_state_v)
   );

   for (genvar g = 0; g < N_DOM; g++) begin : g_seq
      pwr_seq_dom #(.PUP_CYC(PUP_CYC), .MOD_CYC(MOD_CYC)) u_dom (
         .clk        (clk),
         .rst_n      (rst_n),
         .go         (go_v[g]),
         .next_req   (next_v[g]),
         .tgt_state  (tgt_state_v[g]),
         .tgt_lrst_n (tgt_lrst_v[g]),
         .busy       (busy_v[g]),
         .pwr_on     (pwr_v[g]),
         .cur_state  (cur_state_v[g]),
         .cur_lrst_n (cur_lrst_v[g])
      );
      assign mod_clk_en[g] = (cur_state_v[g] == MST_ENABLE);
      assign mod_rst_n[g]  = cur_lrst_v[g];
   end

endmodule

// File: rtl/pwr_seq_chk.sv
module pwr_seq_chk
   import pwr_seq_pkg::*;
#(
   parameter int N_DOM   = 4,
   parameter int PUP_CYC = 6,
   parameter int MOD_CYC = 4
) (
   input logic                  clk,
   input logic                  rst_n,
   input logic                  wr_en,
   input logic [11:0]           wr_addr,
   input logic [31:0]           wr_data,
   input logic [N_DOM-1:0]      busy,
   input logic [N_DOM-1:0]      pwr_on,
   input logic [N_DOM-1:0][5:0] cur_state,
   input logic [N_DOM-1:0]      mod_clk_en,
   input logic [N_DOM-1:0]      mod_rst_n
);

   logic unused_chk;
   assign unused_chk = ^wr_data;

   for (genvar g = 0; g < N_DOM; g++) begin : g_chk
      logic [31:0] dur_q;

      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n)       dur_q <= '0;
         else if (busy[g]) dur_q <= dur_q + 1;
         else              dur_q <= '0;
      end

      AST_BUSY_FROM_CMD: assert property (@(posedge clk) disable iff (!rst_n)
         $rose(busy[g]) |-> $past(wr_en && (wr_addr == OFS_CMD) && wr_data[g])); // R4
      AST_DURATION: assert property (@(posedge clk) disable iff (!rst_n)
         $fell(busy[g]) |-> (dur_q == 32'(MOD_CYC) || dur_q == 32'(PUP_CYC + MOD_CYC))); // R5
      AST_PWR_NEVER_DROPS: assert property (@(posedge clk) disable iff (!rst_n)
         !$fell(pwr_on[g])); // R6
      AST_PWR_UP_IN_TRANSITION: assert property (@(posedge clk) disable iff (!rst_n)
         $rose(pwr_on[g]) |-> busy[g]); // R6
      AST_IDLE_CLK_STABLE: assert property (@(posedge clk) disable iff (!rst_n)
         !busy[g] |=> $stable(mod_clk_en[g])); // R7
      AST_DISABLE_IN_RESET: assert property (@(posedge clk) disable iff (!rst_n)
         (cur_state[g] == MST_DISABLE) |-> !mod_rst_n[g]); // R9
      AST_RELEASE_NEEDS_CLK: assert property (@(posedge clk) disable iff (!rst_n)
         mod_rst_n[g] |-> mod_clk_en[g]); // R9
   end

endmodule

bind pwr_seq_ctrl pwr_seq_chk #(
   .N_DOM(N_DOM), .PUP_CYC(PUP_CYC), .MOD_CYC(MOD_CYC)
) u_chk (
   .clk        (clk),
   .rst_n      (rst_n),
   .wr_en      (wr_en),
   .wr_addr    (wr_addr),
   .wr_data    (wr_data),
   .busy       (busy_v),
   .pwr_on     (pwr_v),
   .cur_state  (cur_state_v),
   .mod_clk_en (mod_clk_en),
   .mod_rst_n  (mod_rst_n)
);

// File: tb/pwr_seq_ctrl_test.sv
module pwr_seq_ctrl_test;

   localparam int N   = 4;
   localparam int PUP = 6;
   localparam int MOD = 4;

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic          wr_en = 1'b0;
   logic [11:0]   wr_addr = '0;
   logic [31:0]   wr_data = '0;
   logic [11:0]   rd_addr = '0;
   logic [31:0]   rd_data;
   logic [N-1:0]  mod_clk_en;
   logic [N-1:0]  mod_rst_n;

   int total = 0;
   int bad   = 0;

   pwr_seq_ctrl #(.N_DOM(N), .PUP_CYC(PUP), .MOD_CYC(MOD)) uut (
      .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr),
      .wr_data(wr_data), .rd_addr(rd_addr), .rd_data(rd_data),
      .mod_clk_en(mod_clk_en), .mod_rst_n(mod_rst_n)
   );

   always #10 clk = ~clk;

   task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
      total++;
      if (act !== exp) begin
         bad++;
         $display("FAIL %s actual=%h expected=%h", req, act, exp);
      end
   endtask

   task automatic do_wr(input logic [11:0] a, input logic [31:0] d);
      @(negedge clk);
      wr_en = 1'b1; wr_addr = a; wr_data = d;
      @(negedge clk);
      wr_en = 1'b0;
   endtask

   task automatic do_rd(input logic [11:0] a, output logic [31:0] d);
      rd_addr = a;
      #1;
      d = rd_data;
   endtask

   function automatic logic [31:0] mstat(input int st, input bit rel, input bit ck);
      return 32'(st) | (32'(rel) << 8) | (32'(ck) << 12);
   endfunction

   // issue a command and count busy cycles of domain d
   task automatic run_go(input logic [31:0] mask, input int d, output int n, output bit moved);
      logic c0;
      c0 = mod_clk_en[d];
      do_wr(12'h120, mask);
      n = 0; moved = 0;
      rd_addr = 12'h128;
      #1;
      while (rd_data[d] && n < 1000) begin
         n++;
         if (mod_clk_en[d] !== c0) moved = 1;
         @(negedge clk); #1;
      end
   endtask

   task automatic t_reset;
      logic [31:0] v;
      do_rd(12'h128, v); check("R1 busy", v, 0);
      for (int d = 0; d < N; d++) begin
         do_rd(12'(12'h200 + 4*d), v); check("R1 domstat", v, 0);
         do_rd(12'(12'h800 + 4*d), v); check("R1 modstat", v, 0);
      end
      check("R1 clk_en", 32'(mod_clk_en), 0);
      check("R1 rst_n", 32'(mod_rst_n), 0);
   endtask

   task automatic t_regmap;
      logic [31:0] v;
      do_wr(12'hA08, 32'hFFFF_FFFF);
      do_rd(12'hA08, v); check("R2 modctl fields", v, 32'h8000_013F);
      do_rd(12'hA09, v); check("R3 misaligned", v, 0);
      do_wr(12'h308, 32'hFFFF_FFFF);
      do_rd(12'h308, v); check("R2 domctl field", v, 1);
      do_rd(12'h808, v); check("R7 modstat unchanged", v, 0);
      check("R7 clk_en unchanged", 32'(mod_clk_en), 0);
      do_wr(12'hA08, 0);
      do_wr(12'h308, 0);
      do_rd(12'h120, v); check("R4 cmd reads zero", v, 0);
      do_wr(12'hA10, 32'hFFFF_FFFF);
      do_rd(12'hA10, v); check("R3 index out of range", v, 0);
      do_rd(12'hA00, v); check("R3 no alias write", v, 0);
      do_rd(12'h400, v); check("R3 unmapped page", v, 0);
      do_rd(12'h210, v); check("R3 domstat out of range", v, 0);
   endtask

   task automatic t_enable_plain;
      logic [31:0] v; int n; bit mv;
      do_wr(12'hA00, 32'h0000_0103);
      run_go(32'h1, 0, n, mv);
      check("R5 plain duration", 32'(n), MOD);
      check("R7 no change while busy", 32'(mv), 0);
      do_rd(12'h200, v); check("R6 stays off", v, 0);
      do_rd(12'h800, v); check("R8 modstat enable", v, mstat(3, 1, 1));
      check("R8 clk_en0", 32'(mod_clk_en[0]), 1);
      check("R9 rst_n0 released", 32'(mod_rst_n[0]), 1);
   endtask

   task automatic t_powerup;
      logic [31:0] v; int n; bit mv;
      do_wr(12'h304, 32'h1);
      do_wr(12'hA04, 32'h0000_0003);
      run_go(32'h2, 1, n, mv);
      check("R5 powerup duration", 32'(n), PUP + MOD);
      check("R7 no change while busy", 32'(mv), 0);
      do_rd(12'h204, v); check("R6 domain on", v, 1);
      do_rd(12'h804, v); check("R9 modstat reset held", v, mstat(3, 0, 1));
      check("R9 rst_n1 held", 32'(mod_rst_n[1]), 0);
      do_wr(12'hA04, 32'h0000_0103);
      run_go(32'h2, 1, n, mv);
      check("R5 already on duration", 32'(n), MOD);
      check("R9 rst_n1 released", 32'(mod_rst_n[1]), 1);
   endtask

   task automatic t_disable;
      logic [31:0] v; int n; bit mv;
      do_wr(12'hA00, 32'h0000_0102);
      run_go(32'h1, 0, n, mv);
      check("R5 disable duration", 32'(n), MOD);
      do_rd(12'h800, v); check("R9 disable forces reset", v, mstat(2, 0, 0));
      check("R8 clk_en0 off", 32'(mod_clk_en[0]), 0);
      check("R9 rst_n0 low", 32'(mod_rst_n[0]), 0);
      check("R11 other domain kept", 32'(mod_clk_en[1]), 1);
   endtask

   task automatic t_busy_ignore;
      logic [31:0] v; int n;
      do_wr(12'h308, 32'h1);
      do_wr(12'hA08, 32'h0000_0103);
      do_wr(12'h120, 32'h4);
      n = 0;
      rd_addr = 12'h128;
      #1;
      while (rd_data[2] && n < 1000) begin
         n++;
         if (n == 3) begin
            wr_en = 1'b1; wr_addr = 12'h120; wr_data = 32'h4;
         end else begin
            wr_en = 1'b0;
         end
         @(negedge clk); #1;
      end
      wr_en = 1'b0;
      check("R10 duration not extended", 32'(n), PUP + MOD);
      repeat (3) @(negedge clk);
      do_rd(12'h128, v); check("R10 no queued transition", v, 0);
      do_rd(12'h808, v); check("R10 result", v, mstat(3, 1, 1));
   endtask

   task automatic t_concurrent;
      logic [31:0] v; int n2, n3, guard;
      do_wr(12'h30C, 32'h1);
      do_wr(12'hA0C, 32'h0000_0103);
      do_wr(12'hA08, 32'h0000_0001);
      do_wr(12'h120, 32'hC);
      n2 = 0; n3 = 0; guard = 0;
      rd_addr = 12'h128;
      #1;
      while ((rd_data[2] || rd_data[3]) && guard < 1000) begin
         guard++;
         if (rd_data[2]) n2++;
         if (rd_data[3]) n3++;
         @(negedge clk); #1;
      end
      check("R11 domain2 duration", 32'(n2), MOD);
      check("R11 domain3 duration", 32'(n3), PUP + MOD);
      do_rd(12'h808, v); check("R11 domain2 syncrst", v, mstat(1, 0, 0));
      do_rd(12'h80C, v); check("R11 domain3 enable", v, mstat(3, 1, 1));
      check("R8 clk_en pattern", 32'(mod_clk_en), 32'hA);
   endtask

   initial begin
      repeat (20 * 1000) @(negedge clk);
      total++; bad++;
      $display("FAIL watchdog expired actual=running expected=finished");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
   end

   initial begin
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      t_reset();
      t_regmap();
      t_enable_plain();
      t_powerup();
      t_disable();
      t_busy_ignore();
      t_concurrent();
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
   end

endmodule